// File: doc/BRIEF.md
# Double-Precision Floating-Point Multiplier

This block multiplies two binary64 operands (sign in the top bit, an 11-bit biased exponent, a 52-bit fraction) and delivers the product rounded to nearest, ties to even. It sorts each operand into zero, subnormal, normal, infinity or NaN. Results that need no arithmetic (a NaN, infinity or zero operand) are resolved straight from the accepted inputs and skip the significand multiply. All other operations form the full 106-bit significand product and a working exponent, then round and pack.

Operations where both operands are normal and the product stays in the normal range take a short fixed path. An operation with a subnormal operand, or with a product below the smallest normal exponent, is routed into a one-bit-per-cycle shifter. The shifter brings the product to the right alignment and gathers a sticky bit before rounding. This path is slower but small, and the block flags it with a busy output. The exponent and fraction widths are parameters, so the same logic also serves narrow formats.

Both data sides use valid/ready. Input is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, so it holds one operation at a time. A finished result stays on `out_data`/`out_class` with `out_valid` high and unchanged until `out_ready` is seen. The block returns to idle on that same edge.

Top module: `fpm_mul64`

## Requirements
- R1: `in_ready` is high only while no operation is in flight and no result is waiting. It is high again in the cycle after a result handshake.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_class` stay unchanged.
- R3: For two normal operands whose product is in the normal range, the result is the exact product rounded to nearest with ties to even. A rounding carry raises the exponent.
- R4: If either operand is zero and neither is NaN or infinity, the result is a zero whose sign is the XOR of the operand signs. `out_valid` rises in the cycle right after acceptance.
- R5: A NaN operand, or infinity times zero, gives the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0 (0x7FF8000000000000 in binary64).
- R6: Infinity times a nonzero non-NaN operand gives an infinity whose sign is the XOR of the operand signs.
- R7: A finite product whose rounded exponent reaches the all-ones code gives an infinity of the XOR sign.
- R8: Subnormal operands, with value 0.fraction × 2^(1−bias), are multiplied exactly and then rounded to nearest-even.
- R9: A product below the normal range is delivered as a correctly rounded subnormal, as a zero, or (after a round-up) as the smallest normal.
- R10: `slow_busy` is high for at least one cycle of an operation exactly when that operation is finite, has no zero operand, and either has a subnormal operand or has an unrounded normalized exponent below 1. `in_ready` is low whenever `slow_busy` is high.
- R11: `out_class` codes the result as 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 NaN.
- R12: After reset, `in_ready` is 1 and `out_valid` and `slow_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to accept |
| in_a | input | EW+FW+1 (64) | First operand |
| in_b | input | EW+FW+1 (64) | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | EW+FW+1 (64) | Rounded product |
| out_class | output | 3 | Result class code |
| slow_busy | output | 1 | Iterative shift path active |

## Verification
An 8-bit instance (4-bit exponent, 3-bit fraction) is swept over every first operand against a strided set of second operands. The reference rounds the exact integer product arithmetically. This one sweep covers all operand class pairs, and so separates the bypass, special, fast and iterative paths, including ties to even, rounding carries, overflow and total underflow. Back-pressure is applied on a fixed pattern of results to expose any output that moves while it is held. A handful of binary64 cases then confirm that the full-width instance agrees at the format's edges: the canonical NaN, the smallest subnormal rounded at a tie, and a subnormal that becomes normal.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_SUB  = 3'd1,
    FC_NORM = 3'd2,
    FC_INF  = 3'd3,
    FC_NAN  = 3'd4
  } fclass_e;
endpackage

// File: rtl/fpm_unpack.sv
// Splits one operand into sign, class, significand with hidden bit and
// effective exponent (subnormals use exponent 1).
module fpm_unpack #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic [EW+FW:0]      op,
  output logic                sign,
  output fpm_pkg::fclass_e    cls,
  output logic [FW:0]         sig,
  output logic [EW-1:0]       eff_exp
);
  logic [EW-1:0] expf;
  logic [FW-1:0] frac;

  assign expf = op[EW+FW-1:FW];
  assign frac = op[FW-1:0];
  assign sign = op[EW+FW];

  always_comb begin
    if (expf == '1)      cls = (frac != '0) ? fpm_pkg::FC_NAN : fpm_pkg::FC_INF;
    else if (expf == '0) cls = (frac != '0) ? fpm_pkg::FC_SUB : fpm_pkg::FC_ZERO;
    else                 cls = fpm_pkg::FC_NORM;
  end

  assign sig     = {(expf != '0), frac};
  assign eff_exp = (expf == '0) ? EW'(1) : expf;
endmodule

// File: rtl/fpm_norm_shift.sv
// Holds the product and working exponent. Steps one bit per cycle toward
// exponent 1 (right, collecting sticky) or toward a set MSB (left).
module fpm_norm_shift #(
  parameter int PW = 106,
  parameter int XW = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [PW-1:0]        acc_in,
  input  logic signed [XW-1:0] exp_in,
  output logic [PW-1:0]        acc_q,
  output logic signed [XW-1:0] exp_q,
  output logic                 sticky_q,
  output logic                 done
);
  localparam logic signed [XW-1:0] ONE = XW'(1);

  logic step_r, step_l;

  always_comb begin
    step_r = (exp_q < ONE) && (acc_q != '0);
    step_l = !step_r && (acc_q != '0) && !acc_q[PW-1] && (exp_q > ONE);
    done   = !step_r && !step_l;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      exp_q    <= '0;
      sticky_q <= 1'b0;
    end else if (load) begin
      acc_q    <= acc_in;
      exp_q    <= exp_in;
      sticky_q <= 1'b0;
    end else if (step_r) begin
      acc_q    <= acc_q >> 1;
      sticky_q <= sticky_q | acc_q[0];
      exp_q    <= exp_q + ONE;
    end else if (step_l) begin
      acc_q    <= acc_q << 1;
      exp_q    <= exp_q - ONE;
    end
  end

  // R9: once a bit is lost to the right it stays recorded until a new load
  a_r9_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !load) |=> sticky_q);

  // R8: a left step moves the product without dropping any set bit
  a_r8_left_lossless: assert property (@(posedge clk) disable iff (!rst_n)
    (step_l && !load) |=> (!acc_q[0] && ($countones(acc_q) == $countones($past(acc_q)))));
endmodule

// File: rtl/fpm_round_pack.sv
// Round to nearest-even from the aligned product, then pack and classify.
module fpm_round_pack #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic                   sign,
  input  logic [2*FW+1:0]        acc,
  input  logic                   sticky,
  input  logic signed [EW+1:0]   exp_in,
  output logic [EW+FW:0]         result,
  output fpm_pkg::fclass_e       cls
);
  localparam int PW = 2*FW + 2;
  localparam int XW = EW + 2;
  localparam logic signed [XW-1:0] EMAX = XW'((2**EW) - 1);

  logic [FW:0]          top;
  logic                 guard, rest, inc, carry, hidden;
  logic [FW+1:0]        q;
  logic [FW-1:0]        frac;
  logic signed [XW-1:0] ef;

  always_comb begin
    top    = acc[PW-1:FW+1];
    guard  = acc[FW];
    rest   = sticky | (|acc[FW-1:0]);
    inc    = guard & (rest | top[0]);
    q      = {1'b0, top} + (FW+2)'(inc);
    carry  = q[FW+1];
    ef     = exp_in + $signed({{(XW-1){1'b0}}, carry});
    hidden = carry | q[FW];
    frac   = carry ? '0 : q[FW-1:0];
    if (ef >= EMAX) begin
      result = {sign, {EW{1'b1}}, {FW{1'b0}}};
      cls    = fpm_pkg::FC_INF;
    end else if (hidden) begin
      result = {sign, ef[EW-1:0], frac};
      cls    = fpm_pkg::FC_NORM;
    end else begin
      result = {sign, {EW{1'b0}}, frac};
      cls    = (frac != '0) ? fpm_pkg::FC_SUB : fpm_pkg::FC_ZERO;
    end
  end
endmodule

// File: rtl/fpm_mul64.sv
module fpm_mul64 #(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [EW+FW:0]      in_a,
  input  logic [EW+FW:0]      in_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [EW+FW:0]      out_data,
  output logic [2:0]          out_class,
  output logic                slow_busy
);
  import fpm_pkg::*;

  localparam int W    = EW + FW + 1;
  localparam int PW   = 2*FW + 2;
  localparam int XW   = EW + 2;
  localparam int BIAS = (2**(EW-1)) - 1;
  localparam logic signed [XW-1:0] ONE    = XW'(1);
  localparam logic signed [XW-1:0] BIAS_X = XW'(BIAS);
  localparam logic [W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_NORM, S_OUT} state_e;

  state_e        state;
  logic [W-1:0]  op_a, op_b;
  logic [W-1:0]  res_q;
  logic [2:0]    cls_q;
  logic          slow_q;

  // operand unpack: raw inputs while idle, captured operands afterwards
  logic [W-1:0]  up_src  [2];
  logic          up_sign [2];
  fclass_e       up_cls  [2];
  logic [FW:0]   up_sig  [2];
  logic [EW-1:0] up_exp  [2];

  assign up_src[0] = (state == S_IDLE) ? in_a : op_a;
  assign up_src[1] = (state == S_IDLE) ? in_b : op_b;

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fpm_unpack #(.EW(EW), .FW(FW)) u_unpack (
      .op      (up_src[i]),
      .sign    (up_sign[i]),
      .cls     (up_cls[i]),
      .sig     (up_sig[i]),
      .eff_exp (up_exp[i])
    );
  end

  logic    rsign, any_nan, any_inf, any_zero, special, both_norm;
  logic [W-1:0] spec_res;
  fclass_e spec_cls;

  always_comb begin
    rsign     = up_sign[0] ^ up_sign[1];
    any_nan   = (up_cls[0] == FC_NAN)  || (up_cls[1] == FC_NAN);
    any_inf   = (up_cls[0] == FC_INF)  || (up_cls[1] == FC_INF);
    any_zero  = (up_cls[0] == FC_ZERO) || (up_cls[1] == FC_ZERO);
    both_norm = (up_cls[0] == FC_NORM) && (up_cls[1] == FC_NORM);
    special   = any_nan || any_inf || any_zero;
    if (any_nan || (any_inf && any_zero)) begin
      spec_res = QNAN;
      spec_cls = FC_NAN;
    end else if (any_inf) begin
      spec_res = {rsign, {EW{1'b1}}, {FW{1'b0}}};
      spec_cls = FC_INF;
    end else begin
      spec_res = {rsign, {(W-1){1'b0}}};
      spec_cls = FC_ZERO;
    end
  end

  // significand product and working exponent (MSB of acc weighs 2^(e-bias))
  logic [PW-1:0]        product, acc_in;
  logic signed [XW-1:0] e_raw, e_in;
  logic                 fast;

  always_comb begin
    product = PW'(up_sig[0]) * PW'(up_sig[1]);
    e_raw   = $signed({2'b00, up_exp[0]}) + $signed({2'b00, up_exp[1]}) - BIAS_X + ONE;
    if (both_norm && !product[PW-1]) begin
      acc_in = product << 1;
      e_in   = e_raw - ONE;
    end else begin
      acc_in = product;
      e_in   = e_raw;
    end
    fast = both_norm && (e_in >= ONE);
  end

  logic [PW-1:0]        sh_acc;
  logic signed [XW-1:0] sh_exp;
  logic                 sh_sticky, sh_done;

  fpm_norm_shift #(.PW(PW), .XW(XW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state == S_MUL),
    .acc_in   (acc_in),
    .exp_in   (e_in),
    .acc_q    (sh_acc),
    .exp_q    (sh_exp),
    .sticky_q (sh_sticky),
    .done     (sh_done)
  );

  logic [W-1:0] rp_res;
  fclass_e      rp_cls;

  fpm_round_pack #(.EW(EW), .FW(FW)) u_round (
    .sign   (rsign),
    .acc    (sh_acc),
    .sticky (sh_sticky),
    .exp_in (sh_exp),
    .result (rp_res),
    .cls    (rp_cls)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_a   <= '0;
      op_b   <= '0;
      res_q  <= '0;
      cls_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          op_a <= in_a;
          op_b <= in_b;
          if (special) begin
            res_q <= spec_res;
            cls_q <= spec_cls;
            state <= S_OUT;
          end else begin
            state <= S_MUL;
          end
        end
        S_MUL: begin
          slow_q <= !fast;
          state  <= S_NORM;
        end
        S_NORM: if (sh_done) begin
          res_q  <= rp_res;
          cls_q  <= rp_cls;
          slow_q <= 1'b0;
          state  <= S_OUT;
        end
        S_OUT: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == S_IDLE);
  assign out_valid = (state == S_OUT);
  assign out_data  = res_q;
  assign out_class = cls_q;
  assign slow_busy = (state == S_NORM) && slow_q;

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !slow_busy));

  a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_class)));

  a_r4_zero_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && any_zero && !any_nan && !any_inf) |=> (out_valid && out_class == 3'd0));

  a_r5_canonical_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_class == 3'd4) |-> (out_data == QNAN));

  a_r10_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    slow_busy |-> !in_ready);

  a_r11_class_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_class <= 3'd4));
endmodule

// File: tb/tb_fpm_mul64.sv
module tb_fpm_mul64;
  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  logic s_iv, s_ir, s_ov, s_or, s_busy;
  logic [7:0] s_a, s_b, s_od;
  logic [2:0] s_oc;

  fpm_mul64 #(.EW(4), .FW(3)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_ready(s_ir),
    .in_a(s_a), .in_b(s_b), .out_valid(s_ov), .out_ready(s_or),
    .out_data(s_od), .out_class(s_oc), .slow_busy(s_busy));

  logic d_iv, d_ir, d_ov, d_or, d_busy;
  logic [63:0] d_a, d_b, d_od;
  logic [2:0] d_oc;

  fpm_mul64 dut64 (
    .clk(clk), .rst_n(rst_n), .in_valid(d_iv), .in_ready(d_ir),
    .in_a(d_a), .in_b(d_b), .out_valid(d_ov), .out_ready(d_or),
    .out_data(d_od), .out_class(d_oc), .slow_busy(d_busy));

  int checks = 0;
  int errors = 0;
  bit over = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // Reference for the 8-bit format: sign[7], exponent[6:3] bias 7, fraction[2:0]
  function automatic void ref_small(input logic [7:0] a, input logic [7:0] b,
                                    output logic [7:0] r, output logic [2:0] c,
                                    output bit slow, output string tag);
    int ea, eb, fa, fb, ma, mb, xa, xb, p, e, l, s, er, q, rem, half;
    bit sg, nan_a, nan_b, inf_a, inf_b, z_a, z_b;
    ea = a[6:3]; eb = b[6:3]; fa = a[2:0]; fb = b[2:0];
    sg = a[7] ^ b[7];
    nan_a = (ea == 15) && (fa != 0); nan_b = (eb == 15) && (fb != 0);
    inf_a = (ea == 15) && (fa == 0); inf_b = (eb == 15) && (fb == 0);
    z_a = (ea == 0) && (fa == 0);    z_b = (eb == 0) && (fb == 0);
    slow = 0;
    if (nan_a || nan_b || (inf_a && z_b) || (z_a && inf_b)) begin
      r = 8'h7C; c = 3'd4; tag = "R5";
    end else if (inf_a || inf_b) begin
      r = {sg, 7'h78}; c = 3'd3; tag = "R6";
    end else if (z_a || z_b) begin
      r = {sg, 7'h00}; c = 3'd0; tag = "R4";
    end else begin
      ma = (ea != 0) ? (8 | fa) : fa; xa = (ea != 0) ? ea : 1;
      mb = (eb != 0) ? (8 | fb) : fb; xb = (eb != 0) ? eb : 1;
      p = ma * mb;
      e = xa + xb - 14 - 6;
      l = 0;
      for (int k = 0; k < 16; k++) if (((p >> k) & 1) == 1) l = k + 1;
      s = l - 4;
      er = e + s + 10;
      slow = (ea == 0) || (eb == 0) || (er < 1);
      if (er < 1) begin s = s + (1 - er); er = 1; end
      if (s <= 0) q = p << (-s);
      else if (s > 9) q = 0;
      else begin
        q = p >> s;
        rem = p - (q << s);
        half = 1 << (s - 1);
        if ((rem > half) || ((rem == half) && (q % 2 == 1))) q = q + 1;
      end
      if (q == 16) begin q = 8; er = er + 1; end
      if ((ea == 0) || (eb == 0)) tag = "R8";
      else if (slow) tag = "R9";
      else tag = "R3";
      if (er >= 15) begin
        r = {sg, 7'h78}; c = 3'd3; tag = "R7";
      end else if (q >= 8) begin
        r = {sg, er[3:0], q[2:0]}; c = 3'd2;
      end else begin
        r = {sg, 4'h0, q[2:0]}; c = (q != 0) ? 3'd1 : 3'd0;
      end
    end
  endfunction

  task automatic run_small(input logic [7:0] a, input logic [7:0] b, input int hold);
    logic [7:0] r_exp, got;
    logic [2:0] c_exp, gotc;
    bit slow_exp, busy_seen;
    string tag;
    int lat;
    ref_small(a, b, r_exp, c_exp, slow_exp, tag);
    busy_seen = 0;
    s_a = a; s_b = b; s_iv = 1'b1;
    @(negedge clk);
    s_iv = 1'b0;
    lat = 1;
    while (!s_ov) begin
      busy_seen |= s_busy;
      @(negedge clk);
      lat++;
    end
    got = s_od; gotc = s_oc;
    check(got == r_exp, {tag, " result"}, 64'(got), 64'(r_exp));
    check(gotc == c_exp, "R11 class", 64'(gotc), 64'(c_exp));
    check(busy_seen == slow_exp, "R10 slow_busy", 64'(busy_seen), 64'(slow_exp));
    if (tag == "R4") check(lat == 1, "R4 bypass latency", 64'(lat), 64'd1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(s_ov && !s_ir && s_od == got && s_oc == gotc, "R2 held output", 64'(s_od), 64'(got));
    end
    s_or = 1'b1;
    @(negedge clk);
    s_or = 1'b0;
    check(s_ir && !s_ov, "R1 ready after handshake", 64'(s_ir), 64'd1);
  endtask

  task automatic run64(input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] r_exp, input logic [2:0] c_exp, input string tag);
    d_a = a; d_b = b; d_iv = 1'b1;
    @(negedge clk);
    d_iv = 1'b0;
    while (!d_ov) @(negedge clk);
    check(d_od == r_exp, {tag, " binary64 result"}, d_od, r_exp);
    check(d_oc == c_exp, "R11 binary64 class", 64'(d_oc), 64'(c_exp));
    d_or = 1'b1;
    @(negedge clk);
    d_or = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!over) begin
      over = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    s_iv = 0; s_or = 0; s_a = 0; s_b = 0;
    d_iv = 0; d_or = 0; d_a = 0; d_b = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ir && !s_ov && !s_busy, "R12 reset state", {61'd0, s_ir, s_ov, s_busy}, 64'd4);
    check(d_ir && !d_ov && !d_busy, "R12 reset state binary64", {61'd0, d_ir, d_ov, d_busy}, 64'd4);

    run64(64'h3FF8000000000000, 64'h4000000000000000, 64'h4008000000000000, 3'd2, "R3");
    run64(64'h3FF0000000000001, 64'h3FF0000000000001, 64'h3FF0000000000002, 3'd2, "R3");
    run64(64'h3FF0000000000001, 64'h3FF8000000000000, 64'h3FF8000000000002, 3'd2, "R3 tie even");
    run64(64'h7FF0000000000000, 64'h0000000000000000, 64'h7FF8000000000000, 3'd4, "R5");
    run64(64'h7FF0000000000001, 64'h3FF0000000000000, 64'h7FF8000000000000, 3'd4, "R5");
    run64(64'hFFF0000000000000, 64'h3FF0000000000000, 64'hFFF0000000000000, 3'd3, "R6");
    run64(64'h7FEFFFFFFFFFFFFF, 64'h4000000000000000, 64'h7FF0000000000000, 3'd3, "R7");
    run64(64'h8000000000000000, 64'h4014000000000000, 64'h8000000000000000, 3'd0, "R4");
    run64(64'h0000000000000001, 64'h3FF8000000000000, 64'h0000000000000002, 3'd1, "R8");
    run64(64'h0008000000000000, 64'h4000000000000000, 64'h0010000000000000, 3'd2, "R8");
    run64(64'h0000000000000001, 64'h3FE0000000000000, 64'h0000000000000000, 3'd0, "R9");
    run64(64'h0010000000000000, 64'h3FE0000000000000, 64'h0008000000000000, 3'd1, "R9");

    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        run_small(8'(a), 8'(b), (((a + b) % 7) == 0) ? 2 : 0);
      end
    end

    if (!over) begin
      over = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule